// File: doc/BRIEF.md
# BCD Real-Time Clock with Latched Register Access

This block keeps calendar time in packed BCD: seconds, minutes, hours in 24-hour form, a day-of-week count, date, month and a two-digit year. It advances once per pulse on a one-cycle tick input, which is normally derived from a 1 Hz source elsewhere on the chip. The running counters are never visible to software directly. A byte-wide register port reads a bank of holding registers, and the bank follows the counters only when the host allows it.

Two control bits manage the hand-off. The freeze bit keeps the holding bank still so that a multi-byte read cannot tear, while the counters keep running underneath. The halt bit stops the copy and opens the holding bank to host writes. When the host clears the halt bit, the whole staged time moves into the counters on one clock edge.

Top module: `rtc_latched_core`

## Requirements
- R1: After reset, the registers read as follows. Address 0 (seconds) is 00, address 1 (minutes) is 00, address 2 (hours) is 00 and address 3 (day of week) is 01. Address 4 (date) is 01, address 5 (month) is 01, address 6 (year) is 00 and address 7 (control) is 00. In the control register, bit 7 is the halt bit and bit 6 is the freeze bit.
- R2: With both control bits clear, each tick advances the counters by one second. The holding registers show the new time from the same clock edge.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day.
- R4: Day of week counts 1 to 7. On a day carry it returns from 7 to 1.
- R5: The date wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. February has 28 days, or 29 days when the year value is divisible by 4 (year 00 counts). All other months have 31 days. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: While the freeze bit is set and the halt bit is clear, the holding registers do not change, even across ticks and minute rollovers. The counters keep advancing during this time.
- R7: After the freeze bit is cleared, the holding registers keep their old values until the next tick. On that tick, all of them take the current time together.
- R8: While the halt bit is clear, host writes to addresses 0 to 6 are ignored.
- R9: While the halt bit is set, ticks do not copy the counters into the holding registers. Host writes to addresses 0 to 6 land in the holding registers and read back.
- R10: Writing the control register with bit 7 at 0 while the halt bit is set loads all seven holding values into the counters on that edge. If a tick arrives in the same cycle, the load absorbs it. Later ticks count on from the loaded time.
- R11: When both bits are set, the halt bit dominates: no copy takes place and host time writes are accepted.
- R12: The control register reads back bits 7 and 6 as last written. Bits 5 to 0 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_addr | input | 3 | Register address (0-6 time fields, 7 control) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Read data for the addressed register (combinational) |

## Verification
The hardest situation to reach is a set of counters that differ from what the host sees while the freeze bit is set. Only the next tick after the bit is cleared reveals whether the counters kept running. The stimulus sets a time two seconds before a minute boundary and freezes the bank. It then ticks past the boundary and clears the bit without ticking, so the stale value must persist. One further tick must then expose the advanced minute. The bench also lines up a halt-clearing control write with a tick in the same cycle, to show that the load absorbs the tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int HALT_BIT   = 7;
  localparam int FREEZE_BIT = 6;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

  typedef struct packed {
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] dow;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                         dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [BYTE_W-1:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    leap_year = (s[1:0] == 2'd0);
  endfunction

  function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mon,
                                                 input logic [BYTE_W-1:0] yr);
    case (mon)
      8'h02:                      last_day = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    c_min  = (cur.sec  == 8'h59);
    c_hour = c_min  && (cur.min  == 8'h59);
    c_day  = c_hour && (cur.hour == 8'h23);
    c_mon  = c_day  && (cur.date == last_day(cur.month, cur.year));
    c_year = c_mon  && (cur.month == 8'h12);

    nxt.sec   = c_min  ? 8'h00 : bcd_inc(cur.sec);
    nxt.min   = c_min  ? (c_hour ? 8'h00 : bcd_inc(cur.min))  : cur.min;
    nxt.hour  = c_hour ? (c_day  ? 8'h00 : bcd_inc(cur.hour)) : cur.hour;
    nxt.dow   = c_day  ? ((cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'd1) : cur.dow;
    nxt.date  = c_day  ? (c_mon  ? 8'h01 : bcd_inc(cur.date)) : cur.date;
    nxt.month = c_mon  ? (c_year ? 8'h01 : bcd_inc(cur.month)) : cur.month;
    nxt.year  = c_year ? ((cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year)) : cur.year;
  end
endmodule

// File: rtl/rtc_time_counters.sv
module rtc_time_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  input  rtc_time_t cnt_nxt,
  output rtc_time_t cnt_q
);
  rtc_time_t cnt_d;
  logic      cnt_en;

  always_comb begin
    cnt_en = load || tick;
    cnt_d  = load ? load_val : cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TIME_AT_RESET;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: counters move only on a tick or a load
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R10: a load places the staged time exactly, absorbing a coincident tick
  assert_load_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  // R3: seconds and hours stay within their BCD ranges
  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.sec <= 8'h59) && (cnt_q.hour <= 8'h23));
  // R4: day of week stays within 1..7
  assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.dow >= 8'h01) && (cnt_q.dow <= 8'h07));
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  rtc_time_t         cnt_nxt,
  output logic [BYTE_W-1:0] rd_data,
  output logic              load,
  output rtc_time_t         hold_q
);
  rtc_time_t hold_d;
  logic      hold_en;
  logic      halt_q, freeze_q;
  logic      ctrl_wr, time_wr, copy;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    time_wr = wr_en && (addr != A_CTRL) && halt_q;
    copy    = tick && !freeze_q && !halt_q;
    load    = ctrl_wr && halt_q && !wr_data[HALT_BIT];
    hold_en = copy || time_wr;
    hold_d  = copy ? cnt_nxt : hold_q;
    if (time_wr) begin
      case (addr)
        A_SEC:   hold_d.sec   = wr_data;
        A_MIN:   hold_d.min   = wr_data;
        A_HOUR:  hold_d.hour  = wr_data;
        A_DOW:   hold_d.dow   = wr_data;
        A_DATE:  hold_d.date  = wr_data;
        A_MONTH: hold_d.month = wr_data;
        default: hold_d.year  = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= TIME_AT_RESET;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      freeze_q <= 1'b0;
    end else if (ctrl_wr) begin
      halt_q   <= wr_data[HALT_BIT];
      freeze_q <= wr_data[FREEZE_BIT];
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rd_data = hold_q.sec;
      A_MIN:   rd_data = hold_q.min;
      A_HOUR:  rd_data = hold_q.hour;
      A_DOW:   rd_data = hold_q.dow;
      A_DATE:  rd_data = hold_q.date;
      A_MONTH: rd_data = hold_q.month;
      A_YEAR:  rd_data = hold_q.year;
      default: rd_data = {halt_q, freeze_q, 6'b0};
    endcase
  end

  // R6: frozen bank holds still
  assert_freeze_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !halt_q) |=> $stable(hold_q));
  // R8: with halt clear, only a tick can change the bank
  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !tick) |=> $stable(hold_q));
  // R11: with halt set, only host time writes change the bank
  assert_halt_no_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !(wr_en && addr != A_CTRL)) |=> $stable(hold_q));
  // R12: reserved control bits read zero
  assert_ctrl_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rd_data[5:0] == 6'b0));
endmodule

// File: rtl/rtc_latched_core.sv
module rtc_latched_core
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [BYTE_W-1:0] reg_wr_data,
  output logic [BYTE_W-1:0] reg_rd_data
);
  localparam int SYNC_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_core_n;
  rtc_time_t         cnt_q, cnt_nxt, hold_q;
  logic              load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_W-1];

  rtc_calendar_next u_next (
    .cur (cnt_q),
    .nxt (cnt_nxt)
  );

  rtc_time_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick_1hz),
    .load     (load),
    .load_val (hold_q),
    .cnt_nxt  (cnt_nxt),
    .cnt_q    (cnt_q)
  );

  rtc_host_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick_1hz),
    .addr    (reg_addr),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .cnt_nxt (cnt_nxt),
    .rd_data (reg_rd_data),
    .load    (load),
    .hold_q  (hold_q)
  );

  // R6: counters keep running whatever the control bits say
  assert_runs_frozen_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick_1hz && !load) |=> !$stable(cnt_q.sec));
endmodule

// File: tb/tb_rtc_latched_core.sv
`timescale 1ns/1ps
module tb_rtc_latched_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz;
  logic [2:0] reg_addr;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  rtc_latched_core dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  // behavioural model: index 0 sec .. 6 year, binary values
  int mc[7];
  int mh[7];
  bit m_halt, m_frz;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction
  function automatic int mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    mc = '{0, 0, 0, 1, 1, 1, 0};
    mh = mc;
    m_halt = 0;
    m_frz = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int n[7];
      bit ctrl_w, ld;
      n = mc;
      n[0]++;
      if (n[0] == 60) begin
        n[0] = 0; n[1]++;
        if (n[1] == 60) begin
          n[1] = 0; n[2]++;
          if (n[2] == 24) begin
            n[2] = 0;
            n[3] = (n[3] == 7) ? 1 : n[3] + 1;
            n[4]++;
            if (n[4] > mdays(mc[5], mc[6])) begin
              n[4] = 1; n[5]++;
              if (n[5] == 13) begin
                n[5] = 1;
                n[6] = (n[6] + 1) % 100;
              end
            end
          end
        end
      end
      ctrl_w = reg_wr_en && reg_addr == 3'd7;
      ld = ctrl_w && m_halt && !reg_wr_data[7];
      if (ld) mc = mh;
      else if (tick_1hz) mc = n;
      if (tick_1hz && !m_frz && !m_halt) mh = n;
      if (reg_wr_en && reg_addr != 3'd7 && m_halt) mh[reg_addr] = from_bcd(int'(reg_wr_data));
      if (ctrl_w) begin
        m_halt = reg_wr_data[7];
        m_frz  = reg_wr_data[6];
      end
    end
  end

  function automatic int model_read(int a);
    if (a == 7) return (m_halt ? 128 : 0) | (m_frz ? 64 : 0);
    return to_bcd(mh[a]);
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      n_checks++;
      if (int'(reg_rd_data) != model_read(int'(reg_addr))) begin
        n_fail++;
        $display("FAIL R2 model addr %0d actual %h expected %h", reg_addr, reg_rd_data,
                 model_read(int'(reg_addr)));
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #2;
    n_checks++;
    if (reg_rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rd_data, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    write_reg(3'd7, 8'h80);
    write_reg(3'd0, s);  write_reg(3'd1, mi); write_reg(3'd2, h);
    write_reg(3'd3, dw); write_reg(3'd4, dt); write_reg(3'd5, mo);
    write_reg(3'd6, y);
    write_reg(3'd7, 8'h00);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_1hz = 1'b0; reg_addr = 3'd0; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    expect_reg(3'd0, 8'h00, "R1"); expect_reg(3'd1, 8'h00, "R1");
    expect_reg(3'd2, 8'h00, "R1"); expect_reg(3'd3, 8'h01, "R1");
    expect_reg(3'd4, 8'h01, "R1"); expect_reg(3'd5, 8'h01, "R1");
    expect_reg(3'd6, 8'h00, "R1"); expect_reg(3'd7, 8'h00, "R1");

    // R2 plain counting
    do_ticks(3);
    expect_reg(3'd0, 8'h03, "R2");

    // R9 halt stops copy, writes land
    write_reg(3'd7, 8'h80);
    expect_reg(3'd7, 8'h80, "R12");
    do_ticks(1);
    expect_reg(3'd0, 8'h03, "R9");
    write_reg(3'd0, 8'h50);
    expect_reg(3'd0, 8'h50, "R9");

    // R3 R4 R5 rollover into March of a non-leap year
    set_time(8'h50, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    do_ticks(10);
    expect_reg(3'd0, 8'h00, "R3"); expect_reg(3'd1, 8'h00, "R3");
    expect_reg(3'd2, 8'h00, "R3"); expect_reg(3'd3, 8'h01, "R4");
    expect_reg(3'd4, 8'h01, "R5"); expect_reg(3'd5, 8'h03, "R5");
    expect_reg(3'd6, 8'h23, "R5");

    // R5 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    do_ticks(1);
    expect_reg(3'd4, 8'h29, "R5"); expect_reg(3'd5, 8'h02, "R5");
    expect_reg(3'd3, 8'h04, "R4");
    do_ticks(86400 - 86400 + 0);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    do_ticks(1);
    expect_reg(3'd4, 8'h01, "R5"); expect_reg(3'd5, 8'h03, "R5");

    // R5 30-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    do_ticks(1);
    expect_reg(3'd4, 8'h01, "R5"); expect_reg(3'd5, 8'h05, "R5");

    // R5 year wrap, then year 00 leap
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    do_ticks(1);
    expect_reg(3'd4, 8'h01, "R5"); expect_reg(3'd5, 8'h01, "R5");
    expect_reg(3'd6, 8'h00, "R5"); expect_reg(3'd3, 8'h06, "R4");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    do_ticks(1);
    expect_reg(3'd4, 8'h29, "R5");

    // R8 write ignored when halt clear
    write_reg(3'd0, 8'h33);
    expect_reg(3'd0, 8'h00, "R8");

    // R6 R7 freeze across a minute rollover
    set_time(8'h58, 8'h00, 8'h12, 8'h01, 8'h15, 8'h06, 8'h21);
    write_reg(3'd7, 8'h40);
    expect_reg(3'd7, 8'h40, "R12");
    for (int i = 0; i < 5; i++) begin
      do_ticks(1);
      expect_reg(3'd0, 8'h58, "R6");
      expect_reg(3'd1, 8'h00, "R6");
    end
    write_reg(3'd7, 8'h00);
    expect_reg(3'd0, 8'h58, "R7");
    do_ticks(1);
    expect_reg(3'd0, 8'h04, "R7"); expect_reg(3'd1, 8'h01, "R6");
    expect_reg(3'd2, 8'h12, "R7");

    // R11 both bits set
    write_reg(3'd7, 8'hC0);
    expect_reg(3'd7, 8'hC0, "R12");
    do_ticks(1);
    expect_reg(3'd0, 8'h04, "R11");
    write_reg(3'd0, 8'h20);
    expect_reg(3'd0, 8'h20, "R11");
    write_reg(3'd7, 8'h00);
    do_ticks(1);
    expect_reg(3'd0, 8'h21, "R10"); expect_reg(3'd1, 8'h01, "R10");

    // R12 reserved bits
    write_reg(3'd7, 8'hFF);
    expect_reg(3'd7, 8'hC0, "R12");
    write_reg(3'd7, 8'h3F);
    expect_reg(3'd7, 8'h00, "R12");

    // R10 load with a coincident tick
    write_reg(3'd7, 8'h80);
    write_reg(3'd0, 8'h10);
    @(negedge clk);
    reg_addr = 3'd7; reg_wr_data = 8'h00; reg_wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; tick_1hz = 1'b0;
    expect_reg(3'd0, 8'h10, "R10");
    do_ticks(1);
    expect_reg(3'd0, 8'h11, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule